// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block sets the operating mode of a CAN protocol controller: sleep, initialization or normal. Software asks for a mode through a sleep-request bit and an init-request level. The block moves the controller only when no frame is in flight. It reports where the controller stands through sleep-acknowledge, init-acknowledge and a busy flag. It also drives one enable that gates the bit-stream engine's transmitter and receiver.

The sleep request is a register inside the block. Software writes it through a write strobe and a value. Hardware can also clear it: this happens when automatic wakeup is on and a start-of-frame arrives while the controller sleeps. The controller does not go straight from sleep or initialization to normal. It first passes through a synchronizing phase, and stays there until the receive line has shown the bus idle for a parameterized number of consecutive recessive bits. The default is 11. All pins are plain control and status levels or pulses. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `can_mode_seq`

## Requirements
- R1: During and right after reset, sleep_req=1, sleep_ack=1, init_ack=0, busy=0 and bus_en=0.
- R2: While the controller is in normal mode with sleep_req=1, it stays in normal mode as long as frame_active=1. sleep_ack rises one cycle after the first clock edge that samples frame_active=0.
- R3: When init_req=1, the block enters initialization mode (init_ack=1) one cycle after the first clock edge that samples frame_active=0. It never enters it on an edge where frame_active=1.
- R4: In the synchronizing phase, busy=1 and bus_en=0. When that phase follows initialization, init_ack stays 1 throughout it. Normal mode (bus_en=1, init_ack=0, busy=0) starts on the clock edge after the edge that takes the eleventh consecutive recessive sample.
- R5: A sample counts only on a cycle with bit_tick=1. A dominant sample (rx_bit=0) taken on a bit_tick restarts the count from zero. rx_bit on cycles without bit_tick has no effect.
- R6: With auto_wake_en=1, sof_det=1 while in sleep mode clears sleep_req on the next edge. The synchronizing phase starts one edge later.
- R7: With auto_wake_en=0, sof_det has no effect: sleep_req and sleep_ack stay 1.
- R8: When software writes sleep_req to 0 in sleep mode, the block leaves sleep mode for the synchronizing phase on the following edge.
- R9: When init_req=1 and sleep_req=1 together, the block enters initialization mode, not sleep mode.
- R10: sleep_ack and init_ack are never both 1. bus_en=1 only when sleep_ack, init_ack and busy are all 0.
- R11: A software write to sleep_req in the same cycle as a hardware wake clear takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_wr_en | input | 1 | Software write strobe for the sleep request |
| sleep_wr_val | input | 1 | Value written to the sleep request |
| init_req | input | 1 | Software initialization request level |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| sof_det | input | 1 | Start-of-frame detect pulse |
| frame_active | input | 1 | A frame is being sent or received |
| auto_wake_en | input | 1 | Automatic wakeup enable |
| sleep_req | output | 1 | Current sleep request register value |
| sleep_ack | output | 1 | Controller is in sleep mode |
| init_ack | output | 1 | Controller is in, or synchronizing out of, initialization mode |
| busy | output | 1 | Synchronizing to the bus |
| bus_en | output | 1 | Transmit and receive enable for the engine |

## Verification
The assertions assume that frame_active is a clean level from the bit-stream engine. They also assume that sof_det is only a single-cycle event, and that neither input depends on the mode outputs within the same cycle. The stimulus respects this. All inputs are driven on the falling edge and held through the next rising edge. Pulses such as bit_tick and sof_det are drawn as independent random bits. Frame activity and the two requests change only occasionally, so each mode is held for many cycles.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_NORMAL = 2'd3
  } mode_e;
endpackage

// File: rtl/can_sleep_req_reg.sv
module can_sleep_req_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic wake_evt,
  output logic req
);
  // software write wins over the hardware wake clear (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req <= 1'b1;
    else if (wr_en)    req <= wr_val;
    else if (wake_evt) req <= 1'b0;
  end
endmodule

// File: rtl/can_idle_counter.sv
module can_idle_counter #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic rx_bit,
  output logic done
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_BITS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (tick) begin
      if (!rx_bit)       cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_req,
  input  logic  sleep_req,
  input  logic  frame_active,
  input  logic  idle_done,
  output mode_e mode,
  output logic  from_init
);
  mode_e mode_nx;
  logic  go_init, go_sleep;

  assign go_init  = init_req & ~frame_active;
  assign go_sleep = sleep_req & ~init_req & ~frame_active;

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      MODE_SLEEP: begin
        if (go_init)                      mode_nx = MODE_INIT;
        else if (!sleep_req && !init_req) mode_nx = MODE_SYNC;
      end
      MODE_INIT: begin
        if (!init_req) begin
          if (go_sleep)        mode_nx = MODE_SLEEP;
          else if (!sleep_req) mode_nx = MODE_SYNC;
        end
      end
      MODE_SYNC: begin
        if (go_init)        mode_nx = MODE_INIT;
        else if (go_sleep)  mode_nx = MODE_SLEEP;
        else if (idle_done) mode_nx = MODE_NORMAL;
      end
      MODE_NORMAL: begin
        if (go_init)       mode_nx = MODE_INIT;
        else if (go_sleep) mode_nx = MODE_SLEEP;
      end
      default: mode_nx = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_SLEEP;
      from_init <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (mode_nx == MODE_SYNC && mode != MODE_SYNC)
        from_init <= (mode == MODE_INIT);
    end
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_wr_en,
  input  logic sleep_wr_val,
  input  logic init_req,
  input  logic rx_bit,
  input  logic bit_tick,
  input  logic sof_det,
  input  logic frame_active,
  input  logic auto_wake_en,
  output logic sleep_req,
  output logic sleep_ack,
  output logic init_ack,
  output logic busy,
  output logic bus_en
);
  mode_e mode;
  logic  from_init, idle_done, wake_evt;

  assign wake_evt = auto_wake_en & sof_det & (mode == MODE_SLEEP);

  can_sleep_req_reg u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(sleep_wr_en), .wr_val(sleep_wr_val),
    .wake_evt(wake_evt), .req(sleep_req)
  );

  can_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .clear(mode != MODE_SYNC), .tick(bit_tick),
    .rx_bit(rx_bit), .done(idle_done)
  );

  can_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sleep_req(sleep_req),
    .frame_active(frame_active), .idle_done(idle_done), .mode(mode),
    .from_init(from_init)
  );

  assign sleep_ack = (mode == MODE_SLEEP);
  assign init_ack  = (mode == MODE_INIT) | ((mode == MODE_SYNC) & from_init);
  assign busy      = (mode == MODE_SYNC);
  assign bus_en    = (mode == MODE_NORMAL);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_wr_en,
  input logic init_req,
  input logic sof_det,
  input logic frame_active,
  input logic auto_wake_en,
  input logic sleep_req,
  input logic sleep_ack,
  input logic init_ack,
  input logic busy,
  input logic bus_en
);
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_ack && init_ack)); // R10
  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (!sleep_ack && !init_ack && !busy)); // R10
  AST_SLEEP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> !$past(frame_active)); // R2
  AST_INIT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(init_ack) && !$past(busy)) |-> !$past(frame_active)); // R3
  AST_NORMAL_VIA_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> $past(busy)); // R4
  AST_AUTO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && sof_det && auto_wake_en && !sleep_wr_en) |=> !sleep_req); // R6
  AST_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && sleep_req && !auto_wake_en && !sleep_wr_en && !init_req) |=> (sleep_req && sleep_ack)); // R7
  AST_INIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && sleep_req && !frame_active) |=> (init_ack && !sleep_ack)); // R9
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_wr_en(sleep_wr_en), .init_req(init_req),
  .sof_det(sof_det), .frame_active(frame_active), .auto_wake_en(auto_wake_en),
  .sleep_req(sleep_req), .sleep_ack(sleep_ack), .init_ack(init_ack),
  .busy(busy), .bus_en(bus_en)
);

// File: tb/sim_can_mode_seq.sv
module sim_can_mode_seq;
  localparam int IDLE = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_wr_en = 0, sleep_wr_val = 0, init_req = 0, rx_bit = 1;
  logic bit_tick = 0, sof_det = 0, frame_active = 0, auto_wake_en = 0;
  logic sleep_req, sleep_ack, init_ack, busy, bus_en;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // bench model: 0 sleep, 1 init, 2 sync, 3 normal
  int m_mode = 0, m_cnt = 0;
  bit m_sq = 1, m_fi = 0;

  always #10 clk = ~clk;

  can_mode_seq #(.IDLE_BITS(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_wr_en(sleep_wr_en), .sleep_wr_val(sleep_wr_val),
    .init_req(init_req), .rx_bit(rx_bit), .bit_tick(bit_tick), .sof_det(sof_det),
    .frame_active(frame_active), .auto_wake_en(auto_wake_en), .sleep_req(sleep_req),
    .sleep_ack(sleep_ack), .init_ack(init_ack), .busy(busy), .bus_en(bus_en)
  );

  function automatic int next_mode(int md, bit sq, bit ir, bit fa, int cnt);
    bit gi = ir && !fa;
    bit gs = sq && !ir && !fa;
    case (md)
      0: return gi ? 1 : ((!sq && !ir) ? 2 : 0);
      1: return ir ? 1 : (gs ? 0 : (!sq ? 2 : 1));
      2: return gi ? 1 : (gs ? 0 : ((cnt == IDLE) ? 3 : 2));
      default: return gi ? 1 : (gs ? 0 : 3);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_sq = 1; m_fi = 0;
    end else begin
      int nm;
      bit wake;
      nm = next_mode(m_mode, m_sq, init_req, frame_active, m_cnt);
      wake = auto_wake_en && sof_det && (m_mode == 0);
      if (m_mode != 2) m_cnt = 0;
      else if (bit_tick) m_cnt = !rx_bit ? 0 : ((m_cnt < IDLE) ? m_cnt + 1 : m_cnt);
      if (nm == 2 && m_mode != 2) m_fi = (m_mode == 1);
      if (sleep_wr_en) m_sq = sleep_wr_val;
      else if (wake) m_sq = 0;
      m_mode = nm;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk("R2", "sleep_ack", sleep_ack, m_mode == 0);
    chk("R3", "init_ack", init_ack, (m_mode == 1) || (m_mode == 2 && m_fi));
    chk("R4", "busy", busy, m_mode == 2);
    chk("R10", "bus_en", bus_en, m_mode == 3);
    chk("R6", "sleep_req", sleep_req, m_sq);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    sleep_wr_en = 0; sof_det = 0; bit_tick = 0;
  endtask

  task automatic ticks(int n, logic rx);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; rx_bit = rx; step();
    end
    rx_bit = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "sleep_req", sleep_req, 1); chk("R1", "sleep_ack", sleep_ack, 1);
    chk("R1", "init_ack", init_ack, 0);   chk("R1", "busy", busy, 0);
    chk("R1", "bus_en", bus_en, 0);
    rst_n = 1;
    chk("R1", "sleep_ack after release", sleep_ack, 1);

    // R8: software wake
    sleep_wr_en = 1; sleep_wr_val = 0; step();
    chk("R8", "still asleep one edge after write", sleep_ack, 1);
    step();
    chk("R8", "sync after write", busy, 1);
    chk("R4", "no init_ack when coming from sleep", init_ack, 0);

    // R5: non-tick dominant ignored; R4: exact count
    ticks(5, 1);
    rx_bit = 0; step(); rx_bit = 1;
    ticks(6, 1);
    chk("R4", "busy at eleventh sample", busy, 1);
    step();
    chk("R5", "normal after 11 with ignored non-tick dominant", bus_en, 1);

    // R2: sleep deferred by frame
    frame_active = 1; sleep_wr_en = 1; sleep_wr_val = 1; step();
    step(); step();
    chk("R2", "normal held during frame", bus_en, 1);
    frame_active = 0; step();
    chk("R2", "sleep after frame", sleep_ack, 1);

    // R7: no auto wake
    auto_wake_en = 0; sof_det = 1; step(); step();
    chk("R7", "sleep_req kept", sleep_req, 1);
    chk("R7", "sleep_ack kept", sleep_ack, 1);

    // R11: write beats wake clear
    auto_wake_en = 1; sof_det = 1; sleep_wr_en = 1; sleep_wr_val = 1; step();
    chk("R11", "write wins", sleep_req, 1);

    // R6: auto wake
    sof_det = 1; step();
    chk("R6", "sleep_req cleared", sleep_req, 0);
    step();
    chk("R6", "sync after wake", busy, 1);

    // R5: dominant tick restarts count
    ticks(10, 1); ticks(1, 0); ticks(10, 1); step();
    chk("R5", "dominant restarts count", busy, 1);
    ticks(1, 1); step();
    chk("R5", "normal after full run", bus_en, 1);

    // R3: init deferred by frame
    frame_active = 1; init_req = 1; step(); step();
    chk("R3", "no init during frame", init_ack, 0);
    frame_active = 0; step();
    chk("R3", "init entered", init_ack, 1);

    // R4: init_ack held through sync
    init_req = 0; step();
    chk("R4", "init_ack held in sync", init_ack, 1);
    chk("R4", "bus_en low in sync", bus_en, 0);
    ticks(IDLE, 1); step();
    chk("R4", "init_ack cleared in normal", init_ack, 0);

    // R9: init beats sleep
    sleep_wr_en = 1; sleep_wr_val = 1; step();
    init_req = 1; step();
    chk("R9", "init chosen", init_ack, 1);
    chk("R9", "not asleep", sleep_ack, 0);
    init_req = 0; step();
    chk("R9", "sleep after init dropped", sleep_ack, 1);

    // random phase
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 20000; i++) begin
      bit_tick = ($urandom % 4) == 0;
      rx_bit = ($urandom % 10) != 0;
      sof_det = ($urandom % 16) == 0;
      if (($urandom % 24) == 0) frame_active = ~frame_active;
      if (($urandom % 300) == 0) init_req = ~init_req;
      if (($urandom % 200) == 0) auto_wake_en = ~auto_wake_en;
      if (($urandom % 150) == 0) begin
        sleep_wr_en = 1; sleep_wr_val = $urandom % 2;
      end
      step();
    end
    finish_run();
  end
endmodule